// File: doc/BRIEF.md
# Dual-Bank Prioritised Interrupt Controller

This block gathers 32 level interrupt sources and presents them to a processor as two request lines: a normal request and a fast request. Every source first passes through a shared per-source polarity select and may be latched (sticky) until software acknowledges it. Each of the two request lines is served by its own register bank, with its own enable mask, latch state, acknowledge register, priority threshold and a current-source register. The current-source register reports the winning source after priority arbitration.

Software uses it through a simple synchronous register port. A handler reads a bank's status register and, while that is non-zero, reads the current-source register to find the source to service. Reading the acknowledge register discards the latched state of that bank. Each source carries a 4-bit priority in which 0 is the most urgent. A bank only considers sources whose priority value does not exceed the bank's threshold.

Top module: `intc_top`

## Requirements
- R1: After reset all enable masks are 0, all polarity bits are 1, all sticky bits are 0, all priorities are 0, both thresholds are 0xF and both request outputs are 0.
- R2: A write to bank offset 0x08 sets every enable bit written as 1. A write to bank offset 0x0C clears every enable bit written as 1. A read of offset 0x08 returns the current mask.
- R3: With polarity bit i (address 0x200) at 1 the source passes unchanged; at 0 it is inverted before any further processing.
- R4: With sticky bit i (address 0x204) at 0 the pending bit follows the source level. At 1 an asserted source stays pending after it drops, until it is acknowledged.
- R5: A read of bank offset 0x28 returns 0 and clears that bank's latched state. The other bank's latched state is untouched.
- R6: Raw status (offset 0x04) holds the pending bits after polarity and latching, before the mask. Status (offset 0x00) is raw status ANDed with the bank's enable mask.
- R7: Current source (offset 0x20) returns the eligible source with the lowest priority value, ties going to the lowest source number, and 0 when none is eligible. Priority of source i is at address 0x300 + 4*i.
- R8: A source is eligible only if it is in status and its priority value is less than or equal to the bank threshold (offset 0x2C). A threshold of 0xF accepts all.
- R9: Each request output is high exactly one clock after its bank has at least one eligible source. Bank 0 (base 0x000) drives the normal request and bank 1 (base 0x100) drives the fast request.
- R10: The two banks have independent enable masks, thresholds and latched state over the shared source configuration.
- R11: A sticky source asserted in the same cycle as an acknowledge read of its bank stays latched.
- R12: Read data appears on the read-data port one clock after the read strobe. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source levels |
| addr_i | input | 12 | Byte address of the register port |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one clock after the read strobe |
| req_norm_o | output | 1 | Normal interrupt request (bank 0) |
| req_fast_o | output | 1 | Fast interrupt request (bank 1) |

## Verification
Two functions can fall in the same clock cycle: an acknowledge read that clears a bank's latched sources, and a fresh assertion of a sticky source. The bench provokes this by raising a sticky source for a single cycle in the very cycle that carries the acknowledge read strobe. The source then drops, so only the latch can remember it. The outcome is judged by reading raw status afterwards: the bit must still be set. A second check confirms that an acknowledge of a source that is no longer asserted does clear it, so the two outcomes are told apart.

// File: rtl/intc_pkg.sv
// Package intc_pkg
// Register offsets shared by the controller and its bench-facing documentation.
// Assumes byte addressing with 32-bit words.
package intc_pkg;
    localparam int NUM_BANKS = 2;

    // Offsets inside one bank (byte offsets, low 8 address bits)
    localparam logic [7:0] OFF_STAT   = 8'h00;
    localparam logic [7:0] OFF_RAW    = 8'h04;
    localparam logic [7:0] OFF_EN_SET = 8'h08;
    localparam logic [7:0] OFF_EN_CLR = 8'h0C;
    localparam logic [7:0] OFF_CUR    = 8'h20;
    localparam logic [7:0] OFF_ACK    = 8'h28;
    localparam logic [7:0] OFF_THR    = 8'h2C;

    // Shared configuration area
    localparam logic [11:0] ADR_POL       = 12'h200;
    localparam logic [11:0] ADR_STICKY    = 12'h204;
    localparam logic [11:0] ADR_PRIO_BASE = 12'h300;
endpackage

// File: rtl/intc_arb.sv
// Module intc_arb
// Combinational priority selector: picks the eligible source with the lowest
// priority value; on equal values the lowest index wins. Reports index 0 and
// valid low when nothing is eligible. Assumes N is a power of two.
module intc_arb #(
    parameter int N  = 32,
    parameter int PW = 4,
    localparam int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    elig_i,
    input  logic [N*PW-1:0] prio_i,
    output logic            valid_o,
    output logic [ID_W-1:0] id_o
);
    // Linear scan; strict less-than keeps the lower index on ties
    always_comb begin
        logic [PW-1:0] best;
        best    = '1;
        valid_o = 1'b0;
        id_o    = '0;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (!valid_o || prio_i[i*PW +: PW] < best)) begin
                best    = prio_i[i*PW +: PW];
                valid_o = 1'b1;
                id_o    = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
// Module intc_bank
// One request bank: enable mask, per-bank latch state, threshold filter,
// arbitration and a registered request line. Assumes the source vector is
// already polarity-corrected and that writes arrive as single-cycle strobes.
module intc_bank #(
    parameter int N  = 32,
    parameter int PW = 4,
    parameter int DW = 32,
    localparam int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    cond_i,
    input  logic [N-1:0]    sticky_i,
    input  logic [N*PW-1:0] prio_i,
    input  logic            en_set_i,
    input  logic            en_clr_i,
    input  logic            thr_we_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            ack_i,
    output logic [N-1:0]    en_o,
    output logic [N-1:0]    latch_o,
    output logic [N-1:0]    raw_o,
    output logic [N-1:0]    stat_o,
    output logic [N-1:0]    elig_o,
    output logic [PW-1:0]   thr_o,
    output logic            cur_valid_o,
    output logic [ID_W-1:0] cur_id_o,
    output logic            req_o
);
    // Enable mask: set and clear by written ones
    always_ff @(posedge clk) begin
        if (!rst_n)        en_o <= '0;
        else if (en_set_i) en_o <= en_o | wdata_i[N-1:0];
        else if (en_clr_i) en_o <= en_o & ~wdata_i[N-1:0];
    end

    // Threshold register, accepts all priorities after reset
    always_ff @(posedge clk) begin
        if (!rst_n)        thr_o <= '1;
        else if (thr_we_i) thr_o <= wdata_i[PW-1:0];
    end

    // Latch: acknowledge drops old state, a same-cycle assertion still enters
    always_ff @(posedge clk) begin
        if (!rst_n) latch_o <= '0;
        else        latch_o <= ((ack_i ? '0 : latch_o) | cond_i) & sticky_i;
    end

    assign raw_o  = cond_i | latch_o;
    assign stat_o = raw_o & en_o;

    // Threshold filter per source
    for (genvar i = 0; i < N; i++) begin : g_elig
        assign elig_o[i] = stat_o[i] && (prio_i[i*PW +: PW] <= thr_o);
    end

    intc_arb #(.N(N), .PW(PW)) u_arb (
        .elig_i  (elig_o),
        .prio_i  (prio_i),
        .valid_o (cur_valid_o),
        .id_o    (cur_id_o)
    );

    // Registered request line
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= |elig_o;
    end
endmodule

// File: rtl/intc_top.sv
// Module intc_top
// Register-mapped interrupt controller: shared polarity, sticky and priority
// configuration feeding two independent request banks. Read data is
// registered; reading a bank acknowledge register clears its latches.
// Assumes N <= DW and a 12-bit byte address map.
module intc_top #(
    parameter int N      = 32,
    parameter int PW     = 4,
    parameter int DW     = 32,
    parameter int ADDR_W = 12,
    localparam int ID_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              req_norm_o,
    output logic              req_fast_o
);
    import intc_pkg::*;

    logic [11:0]     a12;
    logic            hi_ok;
    logic [N-1:0]    pol_q, sticky_q, cond;
    logic [PW-1:0]   prio_q [N];
    logic [N*PW-1:0] prio_flat;
    logic [11:0]     prio_off;
    logic            prio_hit;
    logic [ID_W-1:0] prio_idx;
    logic [DW-1:0]   rd_val;

    logic            bank_hit  [NUM_BANKS];
    logic            bank_ack  [NUM_BANKS];
    logic [N-1:0]    bank_en   [NUM_BANKS];
    logic [N-1:0]    bank_latch[NUM_BANKS];
    logic [N-1:0]    bank_raw  [NUM_BANKS];
    logic [N-1:0]    bank_stat [NUM_BANKS];
    logic [N-1:0]    bank_elig [NUM_BANKS];
    logic [PW-1:0]   bank_thr  [NUM_BANKS];
    logic            bank_cv   [NUM_BANKS];
    logic [ID_W-1:0] bank_cid  [NUM_BANKS];
    logic            bank_req  [NUM_BANKS];

    assign a12      = addr_i[11:0];
    assign hi_ok    = ((addr_i >> 12) == '0);
    assign cond     = src_i ^ ~pol_q;
    assign prio_off = a12 - ADR_PRIO_BASE;
    assign prio_hit = hi_ok && (a12 >= ADR_PRIO_BASE) && (prio_off < 12'(4 * N))
                      && (a12[1:0] == 2'b00);
    assign prio_idx = prio_off[ID_W+1:2];

    // Polarity and sticky selects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q    <= '1;
            sticky_q <= '0;
        end else if (wr_i && hi_ok) begin
            if (a12 == ADR_POL)    pol_q    <= wdata_i[N-1:0];
            if (a12 == ADR_STICKY) sticky_q <= wdata_i[N-1:0];
        end
    end

    // Per-source priority words
    for (genvar i = 0; i < N; i++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)                                prio_q[i] <= '0;
            else if (wr_i && prio_hit && prio_idx == ID_W'(i)) prio_q[i] <= wdata_i[PW-1:0];
        end
        assign prio_flat[i*PW +: PW] = prio_q[i];
    end

    // Two banks over the shared configuration
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_hit[b] = hi_ok && (a12[11:9] == 3'b000) && (a12[8] == b[0]);
        assign bank_ack[b] = rd_i && bank_hit[b] && (a12[7:0] == OFF_ACK);

        intc_bank #(.N(N), .PW(PW), .DW(DW)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .cond_i      (cond),
            .sticky_i    (sticky_q),
            .prio_i      (prio_flat),
            .en_set_i    (wr_i && bank_hit[b] && a12[7:0] == OFF_EN_SET),
            .en_clr_i    (wr_i && bank_hit[b] && a12[7:0] == OFF_EN_CLR),
            .thr_we_i    (wr_i && bank_hit[b] && a12[7:0] == OFF_THR),
            .wdata_i     (wdata_i),
            .ack_i       (bank_ack[b]),
            .en_o        (bank_en[b]),
            .latch_o     (bank_latch[b]),
            .raw_o       (bank_raw[b]),
            .stat_o      (bank_stat[b]),
            .elig_o      (bank_elig[b]),
            .thr_o       (bank_thr[b]),
            .cur_valid_o (bank_cv[b]),
            .cur_id_o    (bank_cid[b]),
            .req_o       (bank_req[b])
        );
    end

    assign req_norm_o = bank_req[0];
    assign req_fast_o = bank_req[1];

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                case (a12[7:0])
                    OFF_STAT:   rd_val[N-1:0]    = bank_stat[b];
                    OFF_RAW:    rd_val[N-1:0]    = bank_raw[b];
                    OFF_EN_SET: rd_val[N-1:0]    = bank_en[b];
                    OFF_CUR:    rd_val[ID_W-1:0] = bank_cid[b];
                    OFF_THR:    rd_val[PW-1:0]   = bank_thr[b];
                    default:    rd_val           = '0;
                endcase
            end
        end
        if (hi_ok && a12 == ADR_POL)    rd_val[N-1:0]  = pol_q;
        if (hi_ok && a12 == ADR_STICKY) rd_val[N-1:0]  = sticky_q;
        if (prio_hit)                   rd_val[PW-1:0] = prio_q[prio_idx];
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_val;
        else           rdata_o <= '0;
    end
endmodule

// File: rtl/intc_chk.sv
// Module intc_chk
// Property checker for intc_top, attached by the bind statement below.
// Observes the top ports and the bank-level signals of bank 0.
module intc_chk #(
    parameter int N  = 32,
    parameter int DW = 32,
    localparam int ID_W = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_norm,
    input logic            req_fast,
    input logic            wr,
    input logic [11:0]     addr,
    input logic [DW-1:0]   wdata,
    input logic [N-1:0]    cond,
    input logic            ack0,
    input logic [N-1:0]    en0,
    input logic [N-1:0]    raw0,
    input logic [N-1:0]    latch0,
    input logic [N-1:0]    elig0,
    input logic            cv0,
    input logic [ID_W-1:0] cid0
);
    AST_REQ_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!req_norm && !req_fast)); // R1

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 12'h008) |=> ((en0 & $past(wdata[N-1:0])) == $past(wdata[N-1:0]))); // R2

    AST_ACK_DROPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        ack0 |=> ((latch0 & ~$past(cond)) == '0)); // R5

    AST_REQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        req_norm |-> $past((raw0 & en0) != '0)); // R9

    AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        cv0 |-> elig0[cid0]); // R8

    AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cv0 |-> (cid0 == '0)); // R7
endmodule

bind intc_top intc_chk #(.N(N), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_norm (req_norm_o),
    .req_fast (req_fast_o),
    .wr       (wr_i),
    .addr     (a12),
    .wdata    (wdata_i),
    .cond     (cond),
    .ack0     (bank_ack[0]),
    .en0      (bank_en[0]),
    .raw0     (bank_raw[0]),
    .latch0   (bank_latch[0]),
    .elig0    (bank_elig[0]),
    .cv0      (bank_cv[0]),
    .cid0     (bank_cid[0])
);

// File: tb/intc_top_tb.sv
// Bench for intc_top: vector table for arbitration, then directed tests.
module intc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [11:0] addr_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        req_norm_o, req_fast_o;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    intc_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .req_norm_o(req_norm_o), .req_fast_o(req_fast_o)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] stat;
        logic [31:0] cur;
    } vec_t;

    // Priorities used: src3=7, src10=3, src17=3, src30=12, all others 0
    localparam vec_t VEC [6] = '{
        '{32'h0000_0408, 32'h0000_0408, 32'd10},
        '{32'h0002_0400, 32'h0002_0400, 32'd10},
        '{32'h4000_0008, 32'h4000_0008, 32'd3},
        '{32'hC000_0000, 32'hC000_0000, 32'd31},
        '{32'h0000_0000, 32'h0000_0000, 32'd0},
        '{32'h4002_0000, 32'h4002_0000, 32'd17}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 req_norm", {31'd0, req_norm_o}, 32'd0);
        chk("R1 req_fast", {31'd0, req_fast_o}, 32'd0);
        rd(12'h008, d); chk("R1 enable", d, 32'h0);
        rd(12'h02C, d); chk("R1 threshold", d, 32'hF);
        rd(12'h12C, d); chk("R1 threshold bank1", d, 32'hF);
        rd(12'h200, d); chk("R1 polarity", d, 32'hFFFF_FFFF);
        rd(12'h204, d); chk("R1 sticky", d, 32'h0);
        rd(12'h314, d); chk("R1 priority", d, 32'h0);

        // Configuration for the vector table
        wr(12'h30C, 32'd7);
        wr(12'h328, 32'd3);
        wr(12'h344, 32'd3);
        wr(12'h378, 32'd12);
        rd(12'h328, d); chk("R7 priority readback", d, 32'd3);
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h008, d); chk("R2 enable all", d, 32'hFFFF_FFFF);

        // R7 R6 R9 arbitration vectors
        for (int k = 0; k < 6; k++) begin
            set_src(VEC[k].src);
            rd(12'h000, d); chk("R6 status vec", d, VEC[k].stat);
            rd(12'h020, d); chk("R7 current vec", d, VEC[k].cur);
            chk("R9 req_norm vec", {31'd0, req_norm_o}, {31'd0, VEC[k].stat != 0});
            chk("R10 req_fast vec", {31'd0, req_fast_o}, 32'd0);
        end

        // R9 one-cycle latency of the request
        set_src(32'h0);
        @(negedge clk);
        @(negedge clk); src_i = 32'h0000_0001;
        chk("R9 req not yet", {31'd0, req_norm_o}, 32'd0);
        @(negedge clk);
        chk("R9 req after one clock", {31'd0, req_norm_o}, 32'd1);

        // R8 threshold filtering
        wr(12'h02C, 32'd6);
        set_src(32'h0000_0008);
        rd(12'h000, d); chk("R8 status keeps filtered", d, 32'h8);
        rd(12'h020, d); chk("R8 current none", d, 32'd0);
        chk("R8 req filtered", {31'd0, req_norm_o}, 32'd0);
        set_src(32'h0000_0408);
        rd(12'h020, d); chk("R8 current eligible", d, 32'd10);
        chk("R8 req eligible", {31'd0, req_norm_o}, 32'd1);
        wr(12'h02C, 32'hF);

        // R3 polarity
        set_src(32'h0);
        wr(12'h200, 32'hFFFF_FEFF);
        rd(12'h004, d); chk("R3 inverted low source", d, 32'h100);
        set_src(32'h0000_0100);
        rd(12'h004, d); chk("R3 inverted high source", d, 32'h0);
        wr(12'h200, 32'hFFFF_FFFF);

        // R2 enable clear and set; R6 raw versus status
        wr(12'h00C, 32'hFFFF_0000);
        rd(12'h008, d); chk("R2 after clear", d, 32'h0000_FFFF);
        set_src(32'h0001_0001);
        rd(12'h004, d); chk("R6 raw unmasked", d, 32'h0001_0001);
        rd(12'h000, d); chk("R6 status masked", d, 32'h0000_0001);
        wr(12'h008, 32'h0001_0000);
        rd(12'h008, d); chk("R2 after set", d, 32'h0001_FFFF);

        // R10 bank 1 independent
        wr(12'h108, 32'h0000_0010);
        set_src(32'h0000_0010);
        rd(12'h100, d); chk("R10 bank1 status", d, 32'h10);
        rd(12'h120, d); chk("R10 bank1 current", d, 32'd4);
        chk("R10 req_fast high", {31'd0, req_fast_o}, 32'd1);
        set_src(32'h0000_0001);
        @(negedge clk);
        chk("R10 req_fast low", {31'd0, req_fast_o}, 32'd0);
        chk("R10 req_norm high", {31'd0, req_norm_o}, 32'd1);

        // R4 sticky latching and R5 acknowledge per bank
        set_src(32'h0);
        wr(12'h204, 32'h0000_1000);
        set_src(32'h0000_1000);
        set_src(32'h0);
        rd(12'h004, d); chk("R4 latched bank0", d, 32'h1000);
        rd(12'h104, d); chk("R4 latched bank1", d, 32'h1000);
        rd(12'h028, d); chk("R5 ack reads zero", d, 32'h0);
        rd(12'h004, d); chk("R5 bank0 cleared", d, 32'h0);
        rd(12'h104, d); chk("R10 bank1 still latched", d, 32'h1000);
        rd(12'h128, d);
        rd(12'h104, d); chk("R5 bank1 cleared", d, 32'h0);

        // R11 assertion in the acknowledge cycle survives
        @(negedge clk);
        addr_i = 12'h028; rd_i = 1'b1; src_i = 32'h0000_1000;
        @(negedge clk);
        rd_i = 1'b0; src_i = 32'h0;
        rd(12'h004, d); chk("R11 kept across ack", d, 32'h1000);
        rd(12'h028, d);

        // R4 level following when not sticky
        set_src(32'h0000_2000);
        set_src(32'h0);
        rd(12'h004, d); chk("R4 level follows", d, 32'h0);

        // R12 unmapped and read latency
        rd(12'h080, d); chk("R12 unmapped", d, 32'h0);
        rd(12'h400, d); chk("R12 hole", d, 32'h0);
        @(negedge clk);
        addr_i = 12'h200; rd_i = 1'b1;
        chk("R12 no data before clock", rdata_o, 32'h0);
        @(negedge clk);
        rd_i = 1'b0;
        chk("R12 data after clock", rdata_o, 32'hFFFF_FFFF);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end
endmodule